// File: doc/BRIEF.md
# Trigger-Positioned Capture Write Controller

This block is the write side of an on-chip signal recorder. Once armed, it takes a sample of a vector of probed signals on every clock and writes each sample into a circular capture memory. The memory wraps over a configurable record depth. Each clock it tests one trigger input against a selected condition. When the condition first holds, the block marks that sample as the trigger point and writes a fixed number of further samples. It then stops, pulses a finish output and disarms itself, so one arming yields exactly one capture.

The trigger can sit at one of three places in the record: early (30 % history, 70 % after), centred, or late (70 % history, 30 % after). The block latches the memory address of the trigger sample. It also reports how many samples in the record are valid, which covers a trigger that arrives before the history part has filled. A reader can then find the oldest sample at (trigger address − valid + post length) modulo depth, without extra state. The configuration is captured at the arming edge. Reset and arm polarities are build-time options.

Top module: `cap_wr_ctrl`

## Requirements
- R1: While reset is active and afterwards until armed, `wr_en` and `done` are 0, and `trg_addr` and `valid_len` are 0.
- R2: An arm request seen active at a clock edge while idle starts a capture. The sample present at the next edge is written to address 0. Each following edge writes one sample to the next address, wrapping from depth−1 to 0. No write happens while idle, whatever the trigger input does.
- R3: `wr_data` always holds the sample that was present at the same edge that produced `wr_addr` (address and data are aligned).
- R4: Trigger condition encoding on `trg_mode`: 0 = rising edge, 1 = falling edge, 2 = either edge, 3 = input high. Edges compare the trigger input with its value one clock earlier.
- R5: History length P is floor(D·3/10) for `trg_pos` = 0, floor(D·7/10) for 2, and floor(D/2) for 1 or 3, where D is the record depth. Depth values outside 2..2^ADDR_W are clamped into that range.
- R6: `trg_addr` holds the address the trigger sample was written to, from the edge that wrote it until the next trigger.
- R7: After the trigger sample, exactly D−P−1 more samples are written, and then writing stops.
- R8: `done` is a one-cycle pulse in the same cycle as the last write. The block is then idle, and later trigger activity causes no writes and no further pulse.
- R9: `valid_len` is set at the trigger to min(samples written before the trigger, P) + (D−P).
- R10: Arm requests and changes to `trg_mode`, `trg_pos` and `rec_depth` during a capture have no effect on that capture.
- R11: With `RST_HI`/`EN_HI` set to 0, the block behaves identically when reset and arm are driven active-low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, polarity set by RST_HI |
| arm | input | 1 | Arm request, polarity set by EN_HI |
| smp_in | input | SMP_W | Probed signal vector |
| trg_in | input | 1 | Trigger input |
| trg_mode | input | 2 | Trigger condition select |
| trg_pos | input | 2 | Trigger position select |
| rec_depth | input | ADDR_W+1 | Record depth in samples |
| wr_addr | output | ADDR_W | Capture memory write address |
| wr_data | output | SMP_W | Capture memory write data |
| wr_en | output | 1 | Capture memory write enable |
| trg_addr | output | ADDR_W | Address of the trigger sample |
| valid_len | output | ADDR_W+1 | Number of valid samples in the record |
| done | output | 1 | One-cycle finish pulse |

## Verification
A wrong pointer or wrap limit shows at once as a write address that skips or leaves the range. A wrong history length or countdown shows only at the end of a capture: the write count, the cycle of the finish pulse, or the reported valid length is off. A stale arming state shows as writes after the finish pulse, as soon as the trigger moves again. Misaligned address and data show up when the recorded memory is rebuilt from the trigger address and compared with the sample sequence that was driven.

// File: rtl/cap_pkg.sv
package cap_pkg;
   typedef enum logic [1:0] {
      TM_RISE = 2'd0,
      TM_FALL = 2'd1,
      TM_EDGE = 2'd2,
      TM_HIGH = 2'd3
   } trig_mode_e;

   typedef enum logic [1:0] {
      POS_30  = 2'd0,
      POS_50  = 2'd1,
      POS_70  = 2'd2,
      POS_RSV = 2'd3
   } trig_pos_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PRE  = 2'd1,
      ST_POST = 2'd2
   } cap_state_e;
endpackage

// File: rtl/cap_trig_det.sv
module cap_trig_det
   import cap_pkg::*;
(
   input  logic       clk,
   input  logic       rst_a,
   input  logic       trg_in,
   input  logic [1:0] mode,
   output logic       hit
);
   logic prev_q;

   always_ff @(posedge clk) begin
      if (rst_a) prev_q <= 1'b0;
      else       prev_q <= trg_in;
   end

   always_comb begin
      case (trig_mode_e'(mode))
         TM_RISE: hit = trg_in & ~prev_q;
         TM_FALL: hit = ~trg_in & prev_q;
         TM_EDGE: hit = trg_in ^ prev_q;
         default: hit = trg_in;
      endcase
   end
endmodule

// File: rtl/cap_pre_calc.sv
module cap_pre_calc
   import cap_pkg::*;
#(
   parameter int DW = 5
) (
   input  logic [DW-1:0] depth,
   input  logic [1:0]    pos,
   output logic [DW-1:0] pre
);
   always_comb begin
      case (trig_pos_e'(pos))
         POS_30:  pre = DW'((32'(depth) * 3) / 10);
         POS_70:  pre = DW'((32'(depth) * 7) / 10);
         default: pre = depth >> 1;
      endcase
   end
endmodule

// File: rtl/cap_seq.sv
module cap_seq
   import cap_pkg::*;
#(
   parameter int SMP_W = 8,
   parameter int AW    = 4,
   localparam int DW   = AW + 1
) (
   input  logic             clk,
   input  logic             rst_a,
   input  logic             arm_a,
   input  logic [SMP_W-1:0] smp_in,
   input  logic             hit,
   input  logic [1:0]       mode_in,
   input  logic [1:0]       pos_in,
   input  logic [DW-1:0]    depth_in,
   input  logic [DW-1:0]    pre_q,
   output logic [1:0]       mode_q,
   output logic [1:0]       pos_q,
   output logic [DW-1:0]    depth_q,
   output logic             in_post,
   output logic [AW-1:0]    wr_addr,
   output logic [SMP_W-1:0] wr_data,
   output logic             wr_en,
   output logic [AW-1:0]    trg_addr,
   output logic [DW-1:0]    valid_len,
   output logic             done
);
   localparam logic [DW-1:0] MAXD = DW'(2 ** AW);
   localparam logic [DW-1:0] MIND = DW'(2);

   cap_state_e    st;
   logic [AW-1:0] ptr;
   logic [DW-1:0] fill;
   logic [DW-1:0] rem;
   logic [DW-1:0] post_len;
   logic          at_last;

   assign post_len = depth_q - pre_q;
   assign at_last  = ({1'b0, ptr} == depth_q - 1'b1);
   assign in_post  = (st == ST_POST);

   always_ff @(posedge clk) begin
      if (rst_a) begin
         st        <= ST_IDLE;
         ptr       <= '0;
         fill      <= '0;
         rem       <= '0;
         depth_q   <= MIND;
         pos_q     <= '0;
         mode_q    <= '0;
         wr_addr   <= '0;
         wr_data   <= '0;
         wr_en     <= 1'b0;
         trg_addr  <= '0;
         valid_len <= '0;
         done      <= 1'b0;
      end else begin
         wr_en <= 1'b0;
         done  <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (arm_a) begin
                  st     <= ST_PRE;
                  ptr    <= '0;
                  fill   <= '0;
                  pos_q  <= pos_in;
                  mode_q <= mode_in;
                  if (depth_in < MIND)      depth_q <= MIND;
                  else if (depth_in > MAXD) depth_q <= MAXD;
                  else                      depth_q <= depth_in;
               end
            end
            default: begin
               wr_en   <= 1'b1;
               wr_data <= smp_in;
               wr_addr <= ptr;
               ptr     <= at_last ? '0 : ptr + 1'b1;
               if (st == ST_PRE) begin
                  if (hit) begin
                     trg_addr  <= ptr;
                     valid_len <= fill + post_len;
                     rem       <= post_len - 1'b1;
                     if (post_len == DW'(1)) begin
                        done <= 1'b1;
                        st   <= ST_IDLE;
                     end else begin
                        st <= ST_POST;
                     end
                  end else if (fill < pre_q) begin
                     fill <= fill + 1'b1;
                  end
               end else begin
                  rem <= rem - 1'b1;
                  if (rem == DW'(1)) begin
                     done <= 1'b1;
                     st   <= ST_IDLE;
                  end
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/cap_wr_ctrl.sv
module cap_wr_ctrl
   import cap_pkg::*;
#(
   parameter int SMP_W  = 8,
   parameter int ADDR_W = 4,
   parameter bit RST_HI = 1'b1,
   parameter bit EN_HI  = 1'b1,
   localparam int DW    = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              arm,
   input  logic [SMP_W-1:0]  smp_in,
   input  logic              trg_in,
   input  logic [1:0]        trg_mode,
   input  logic [1:0]        trg_pos,
   input  logic [DW-1:0]     rec_depth,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [SMP_W-1:0]  wr_data,
   output logic              wr_en,
   output logic [ADDR_W-1:0] trg_addr,
   output logic [DW-1:0]     valid_len,
   output logic              done
);
   if (SMP_W < 1) begin : g_bad_smp
      $error("cap_wr_ctrl: SMP_W must be at least 1");
   end
   if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_addr
      $error("cap_wr_ctrl: ADDR_W must lie in 2..16");
   end

   logic          rst_a;
   logic          arm_a;
   logic          hit;
   logic [1:0]    mode_q;
   logic [1:0]    pos_q;
   logic [DW-1:0] depth_q;
   logic [DW-1:0] pre_q;
   logic          in_post;

   if (RST_HI) begin : g_rst_hi
      assign rst_a = rst;
   end else begin : g_rst_lo
      assign rst_a = ~rst;
   end

   if (EN_HI) begin : g_en_hi
      assign arm_a = arm;
   end else begin : g_en_lo
      assign arm_a = ~arm;
   end

   cap_trig_det u_det (
      .clk    (clk),
      .rst_a  (rst_a),
      .trg_in (trg_in),
      .mode   (mode_q),
      .hit    (hit)
   );

   cap_pre_calc #(.DW(DW)) u_pre (
      .depth (depth_q),
      .pos   (pos_q),
      .pre   (pre_q)
   );

   cap_seq #(.SMP_W(SMP_W), .AW(ADDR_W)) u_seq (
      .clk       (clk),
      .rst_a     (rst_a),
      .arm_a     (arm_a),
      .smp_in    (smp_in),
      .hit       (hit),
      .mode_in   (trg_mode),
      .pos_in    (trg_pos),
      .depth_in  (rec_depth),
      .pre_q     (pre_q),
      .mode_q    (mode_q),
      .pos_q     (pos_q),
      .depth_q   (depth_q),
      .in_post   (in_post),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .wr_en     (wr_en),
      .trg_addr  (trg_addr),
      .valid_len (valid_len),
      .done      (done)
   );
endmodule

// File: rtl/cap_wr_ctrl_chk.sv
module cap_wr_ctrl_chk #(
   parameter int AW = 4,
   localparam int DW = AW + 1
) (
   input logic          clk,
   input logic          rst_a,
   input logic          wr_en,
   input logic [AW-1:0] wr_addr,
   input logic          done,
   input logic [AW-1:0] trg_addr,
   input logic [DW-1:0] valid_len,
   input logic [DW-1:0] depth_q,
   input logic [DW-1:0] pre_q,
   input logic          in_post
);
   p_addr_range_r2: assert property (@(posedge clk) disable iff (rst_a)
      wr_en |-> ({1'b0, wr_addr} < depth_q));

   p_addr_step_r2: assert property (@(posedge clk) disable iff (rst_a)
      (wr_en && $past(wr_en)) |->
         ({1'b0, wr_addr} == ((({1'b0, $past(wr_addr)} + 1'b1) == depth_q) ?
                               '0 : ({1'b0, $past(wr_addr)} + 1'b1))));

   p_trg_hold_r6: assert property (@(posedge clk) disable iff (rst_a)
      (in_post && $past(in_post)) |-> $stable(trg_addr));

   p_stop_after_done_r7: assert property (@(posedge clk) disable iff (rst_a)
      done |=> !wr_en);

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst_a)
      done |=> !done);

   p_done_last_r8: assert property (@(posedge clk) disable iff (rst_a)
      done |-> wr_en);

   p_valid_len_r9: assert property (@(posedge clk) disable iff (rst_a)
      done |-> (valid_len <= depth_q) && ((valid_len + pre_q) >= depth_q));
endmodule

bind cap_wr_ctrl cap_wr_ctrl_chk #(.AW(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_a     (rst_a),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .done      (done),
   .trg_addr  (trg_addr),
   .valid_len (valid_len),
   .depth_q   (depth_q),
   .pre_q     (pre_q),
   .in_post   (in_post)
);

// File: tb/sim_cap_wr_ctrl.sv
module sim_cap_wr_ctrl;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       arm = 1'b0;
   logic [7:0] smp = '0;
   logic       trg = 1'b0;
   logic [1:0] mode = '0;
   logic [1:0] pos = 2'd1;
   logic [4:0] depth = 5'd16;

   logic [3:0] wr_addr, trg_addr, u1_wr_addr, u1_trg_addr;
   logic [7:0] wr_data, u1_wr_data;
   logic [4:0] vlen, u1_vlen;
   logic       wr_en, done, u1_wr_en, u1_done;

   int n_chk = 0;
   int n_err = 0;
   int nwr = 0;
   int ndone = 0;
   int done_at = 0;
   int addr_err = 0;
   int pol_err = 0;
   int exp_addr = 0;
   int cur_d = 16;
   int base = 5;
   bit fin = 1'b0;
   bit live = 1'b0;
   logic [7:0] ram [16];

   always #10 clk = ~clk;

   cap_wr_ctrl u0 (
      .clk(clk), .rst(rst), .arm(arm), .smp_in(smp), .trg_in(trg),
      .trg_mode(mode), .trg_pos(pos), .rec_depth(depth),
      .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en),
      .trg_addr(trg_addr), .valid_len(vlen), .done(done)
   );

   cap_wr_ctrl #(.RST_HI(1'b0), .EN_HI(1'b0)) u1 (
      .clk(clk), .rst(~rst), .arm(~arm), .smp_in(smp), .trg_in(trg),
      .trg_mode(mode), .trg_pos(pos), .rec_depth(depth),
      .wr_addr(u1_wr_addr), .wr_data(u1_wr_data), .wr_en(u1_wr_en),
      .trg_addr(u1_trg_addr), .valid_len(u1_vlen), .done(u1_done)
   );

   always @(negedge clk) begin
      if (live) begin
         if (wr_en === 1'b1) begin
            ram[wr_addr] = wr_data;
            nwr = nwr + 1;
            if (int'(wr_addr) != exp_addr) addr_err = addr_err + 1;
            exp_addr = (exp_addr + 1 == cur_d) ? 0 : exp_addr + 1;
         end
         if (done === 1'b1) begin
            ndone = ndone + 1;
            done_at = nwr;
         end
         if ({wr_addr, wr_data, wr_en, trg_addr, vlen, done} !==
             {u1_wr_addr, u1_wr_data, u1_wr_en, u1_trg_addr, u1_vlen, u1_done})
            pol_err = pol_err + 1;
      end
   end

   task automatic check(input string name, input int act, input int exp);
      n_chk = n_chk + 1;
      if (act != exp) begin
         n_err = n_err + 1;
         $display("FAIL %s: actual %0d expected %0d", name, act, exp);
      end
   endtask

   function automatic logic trig_val(input int md, input int j, input int k, input int tot);
      case (md)
         0:       return (j == k) || (j == tot + 1);
         1:       return (j < k) || (j == tot);
         2:       return (j >= k) && (j != tot + 1);
         default: return (j == k) || (j == tot + 1);
      endcase
   endfunction

   task automatic t_reset();
      repeat (3) @(negedge clk);
      rst = 1'b0;
      live = 1'b1;
      @(negedge clk);
      check("R1 wr_en after reset", int'(wr_en), 0);
      check("R1 done after reset", int'(done), 0);
      check("R1 trg_addr after reset", int'(trg_addr), 0);
      check("R1 valid_len after reset", int'(vlen), 0);
      trg = 1'b1;
      repeat (2) @(negedge clk);
      trg = 1'b0;
      repeat (2) @(negedge clk);
      check("R2 no write while idle", nwr, 0);
   endtask

   task automatic t_capture(input string tag, input int d, input int p, input int md,
                            input int k, input int rearm_j);
      int pre_n, post_n, tot, pre_len, derr;
      pre_n  = (p == 0) ? (d * 3) / 10 : (p == 2) ? (d * 7) / 10 : d / 2;
      post_n = d - pre_n;
      tot    = k + post_n;
      pre_len = (k < pre_n) ? k : pre_n;
      @(negedge clk);
      mode = md[1:0]; pos = p[1:0]; depth = d[4:0];
      trg = (md == 1) ? 1'b1 : 1'b0;
      repeat (2) @(negedge clk);
      nwr = 0; ndone = 0; done_at = 0; addr_err = 0; exp_addr = 0; cur_d = d;
      arm = 1'b1;
      @(negedge clk);
      arm = 1'b0;
      for (int j = 0; j < tot + 4; j++) begin
         smp = 8'(base + j);
         trg = trig_val(md, j, k, tot);
         arm = (j == rearm_j);
         pos = (j == rearm_j) ? 2'((p + 1) % 3) : p[1:0];
         depth = (j == rearm_j) ? 5'd7 : d[4:0];
         @(negedge clk);
      end
      arm = 1'b0;
      pos = p[1:0];
      check({tag, " R7 write count"}, nwr, tot);
      check({tag, " R8 finish pulses"}, ndone, 1);
      check({tag, " R8 finish on last write"}, done_at, tot);
      check({tag, " R6 trigger address"}, int'(trg_addr), k % d);
      check({tag, " R9 valid length"}, int'(vlen), pre_len + post_n);
      check({tag, " R2 address sequence errors"}, addr_err, 0);
      derr = 0;
      for (int i = 0; i < pre_len + post_n; i++) begin
         int jj;
         jj = k - pre_len + i;
         if (ram[jj % d] !== 8'(base + jj)) derr = derr + 1;
      end
      check({tag, " R3 stored data errors"}, derr, 0);
      base = base + 37;
   endtask

   initial begin
      t_reset();
      t_capture("R5 centred rise", 16, 1, 0, 12, -1);
      t_capture("R9 R5 early partial", 10, 0, 0, 1, -1);
      t_capture("R4 fall late wrap", 16, 2, 1, 30, -1);
      t_capture("R4 either edge R10 rearm", 12, 1, 2, 0, 0);
      t_capture("R4 level R10 rearm", 16, 0, 3, 20, 5);
      check("R11 active-low instance mismatches", pol_err, 0);
      fin = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!fin) begin
         n_chk = n_chk + 1;
         n_err = n_err + 1;
         $display("FAIL watchdog: actual 1 expected 0 (run did not finish)");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule